// File: doc/BRIEF.md
# CSI-2 Packet Data-Type Filter

This block sits between a CSI-2 packet decoder and an image pipeline. Decoded packets arrive as a stream of beats with valid/ready handshaking and start/end markers. The first beat of each packet is its header, which holds a 6-bit data type, a virtual channel and a word count. When type filtering is on, the block forwards only long packets whose data type equals a configured code. Optically black lines (user type 0x37), embedded data and any other unwanted long packets are swallowed whole, so they never reach the pipeline. Short packets such as frame start and frame end always pass while the block is enabled.

Software configures the block through a small word-addressed register port. The filter mode and the accepted type are written to working registers, which have no effect on their own. Setting a self-clearing update bit copies them into shadow registers, and only the shadow registers steer the filter. The copy waits for the next frame-start packet while a frame is open, so the settings never change in the middle of a frame. A 16-bit saturating counter records how many long packets have been discarded.

The sequencer has four states:
- ST_OFF: global enable clear; every beat is consumed and nothing is output.
- ST_HEAD: waiting for a header.
- ST_PASS: forwarding the payload of a kept packet.
- ST_DROP: consuming the payload of a discarded packet.

Its transitions are:
- OFF→HEAD when enabled.
- HEAD→PASS on a kept header without end marker.
- HEAD→DROP on a discarded header without end marker.
- PASS→HEAD and DROP→HEAD on the end beat.
- Any state→OFF when the enable clears.
- Any state→HEAD on a software reset.

Top module: `csi_dt_filter`

Register map (word address on `reg_addr`):
- 0 is the control register:
  - bit 0: enable.
  - bit 1: software reset; write 1 to trigger, reads 0.
  - bits 9:8: lane count.
  - bits 11:10: filter mode.
  - bit 14: spare bit, reset value 1.
  - bit 16: update request.
- 1 holds the working type in bits 5:0 (reset 0x2C).
- 2 holds the drop counter in bits 15:0 (read-only).
- 3 reads back the shadows: type in bits 5:0, mode in bits 9:8.

Header beat layout on `in_data`:
- type in bits 5:0
- channel in bits 7:6
- word count in bits 23:8

## Requirements
- R1: After reset the control register reads 0x00004000, the working type reads 0x2C, the drop counter reads 0 and the shadow register reads 0x02C (mode 00, type 0x2C).
- R2: With shadow mode 00, 10 or 11 every long packet (type 0x10 to 0x3F) is forwarded with all of its beats, whatever its type.
- R3: With shadow mode 01 a long packet whose type equals the shadow type is forwarded unchanged. Its header is the beat marked `out_sop`, and its last beat is marked `out_eop`.
- R4: With shadow mode 01 a long packet of any other type is discarded in full, header and payload. `in_ready` stays high for all of its beats even when `out_ready` is low.
- R5: Short packets (type 0x00 to 0x0F) are forwarded in every mode while enabled.
- R6: While enable (control bit 0) is 0, `out_valid` stays low and every input beat is accepted.
- R7: Writing 1 to control bit 16 sets a pending update that reads back as 1 until the working mode and type are copied to the shadows. The copy happens within one cycle when no frame is open or the block is disabled. After a frame start (type 0x00) and before a frame end (type 0x01), the copy is made only when the next frame-start header is accepted.
- R8: Control bits 9:8 and bit 14 are stored and read back as written and do not change which packets are forwarded.
- R9: Writing 1 to control bit 1 clears the drop counter and the open-frame tracking and returns the sequencer to header wait. The bit always reads 0.
- R10: The drop counter rises by one for each long packet discarded under mode 01 and holds at 0xFFFF.
- R11: While a packet is being forwarded, `in_ready` follows `out_ready`, so a downstream stall holds the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_sop | input | 1 | Input beat is a packet header |
| in_eop | input | 1 | Input beat ends the packet |
| in_data | input | 32 | Input beat data |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_sop | output | 1 | Output beat is a packet header |
| out_eop | output | 1 | Output beat ends the packet |
| out_data | output | 32 | Output beat data |

## Verification
The filter is tried with several packet types in turn:
- a matching RAW12 packet (0x2C) and an optically black line (0x37) under type filtering, which separates keeping from dropping;
- the same 0x37 line and an arbitrary long type under the pass-all and reserved modes, which shows that those modes do not filter;
- frame-start and frame-end short packets, which shows that short packets bypass the type compare.

The update bit is exercised both inside an open frame and outside one, which separates a deferred copy from an immediate one. Backpressure is applied on both a kept and a discarded packet, which shows that only forwarded data can stall the input. A long run of single-beat discarded headers drives the counter into saturation.

// File: rtl/csi_dt_filter_pkg.sv
`timescale 1ns/1ps
package csi_dt_filter_pkg;

    localparam int DT_W   = 6;
    localparam int ADDR_W = 2;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_DTYPE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_DROPS  = 2'd2;
    localparam logic [ADDR_W-1:0] A_SHADOW = 2'd3;

    // control register bit positions
    localparam int B_EN      = 0;
    localparam int B_SWRST   = 1;
    localparam int B_LANE_LO = 8;
    localparam int B_MODE_LO = 10;
    localparam int B_SPARE   = 14;
    localparam int B_UPD     = 16;

    // shadow readback positions
    localparam int B_SHMODE_LO = 8;

    localparam logic [1:0] MODE_BY_TYPE = 2'b01;

    localparam logic [DT_W-1:0] DT_FRAME_START = 6'h00;
    localparam logic [DT_W-1:0] DT_FRAME_END   = 6'h01;
    localparam logic [DT_W-1:0] DT_RESET       = 6'h2C;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_HEAD,
        ST_PASS,
        ST_DROP
    } seq_state_t;

endpackage

// File: rtl/dtf_sat_counter.sv
`timescale 1ns/1ps
module dtf_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign value = cnt_q;
endmodule

// File: rtl/dtf_cfg_regs.sv
`timescale 1ns/1ps
module dtf_cfg_regs
    import csi_dt_filter_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              commit_ok,
    input  logic [CNT_W-1:0]  drop_count,
    output logic              en,
    output logic              sw_rst,
    output logic              filter_on,
    output logic [DT_W-1:0]   sh_dt,
    output logic              upd_pend
);
    logic            en_q;
    logic [1:0]      lanes_q;
    logic [1:0]      mode_q;
    logic            spare_q;
    logic            pend_q;
    logic [DT_W-1:0] wdt_q;
    logic [1:0]      sh_mode_q;
    logic [DT_W-1:0] sh_dt_q;

    logic ctrl_wr;
    logic dt_wr;
    logic unused_wbits;

    assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
    assign dt_wr   = reg_we && (reg_addr == A_DTYPE);
    assign unused_wbits = ^{reg_wdata[REG_W-1:B_UPD+1], reg_wdata[B_SPARE+1],
                            reg_wdata[B_SPARE-1:B_MODE_LO+2],
                            reg_wdata[B_LANE_LO-1:B_SWRST+1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            lanes_q   <= 2'b00;
            mode_q    <= 2'b00;
            spare_q   <= 1'b1;
            pend_q    <= 1'b0;
            wdt_q     <= DT_RESET;
            sh_mode_q <= 2'b00;
            sh_dt_q   <= DT_RESET;
        end else begin
            if (pend_q && commit_ok) begin
                sh_mode_q <= mode_q;
                sh_dt_q   <= wdt_q;
                pend_q    <= 1'b0;
            end
            if (ctrl_wr) begin
                en_q    <= reg_wdata[B_EN];
                lanes_q <= reg_wdata[B_LANE_LO +: 2];
                mode_q  <= reg_wdata[B_MODE_LO +: 2];
                spare_q <= reg_wdata[B_SPARE];
                if (reg_wdata[B_UPD]) begin
                    pend_q <= 1'b1;
                end
            end
            if (dt_wr) begin
                wdt_q <= reg_wdata[DT_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_EN]          = en_q;
                reg_rdata[B_LANE_LO +: 2] = lanes_q;
                reg_rdata[B_MODE_LO +: 2] = mode_q;
                reg_rdata[B_SPARE]       = spare_q;
                reg_rdata[B_UPD]         = pend_q;
            end
            A_DTYPE:  reg_rdata[DT_W-1:0]  = wdt_q;
            A_DROPS:  reg_rdata[CNT_W-1:0] = drop_count;
            A_SHADOW: begin
                reg_rdata[DT_W-1:0]          = sh_dt_q;
                reg_rdata[B_SHMODE_LO +: 2] = sh_mode_q;
            end
        endcase
    end

    assign en        = en_q;
    assign sw_rst    = ctrl_wr && reg_wdata[B_SWRST];
    assign filter_on = (sh_mode_q == MODE_BY_TYPE);
    assign sh_dt     = sh_dt_q;
    assign upd_pend  = pend_q;
endmodule

// File: rtl/dtf_pkt_fsm.sv
`timescale 1ns/1ps
module dtf_pkt_fsm
    import csi_dt_filter_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            sw_rst,
    input  logic            filter_on,
    input  logic [DT_W-1:0] sh_dt,
    input  logic            in_valid,
    input  logic            in_sop,
    input  logic            in_eop,
    input  logic [DT_W-1:0] in_dt,
    input  logic            out_ready,
    output logic            in_ready,
    output logic            out_valid,
    output logic            out_sop,
    output logic            drop_hdr,
    output logic            commit_ok
);
    seq_state_t state_q, state_d;
    logic       frame_q, frame_d;

    logic is_short;
    logic hdr_keep;
    logic take;
    logic at_head;
    logic fs_take;

    assign is_short = (in_dt[DT_W-1:DT_W-2] == 2'b00);
    assign hdr_keep = is_short || !filter_on || (in_dt == sh_dt);
    assign at_head  = (state_q == ST_HEAD);
    assign take     = in_valid && in_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            frame_q <= 1'b0;
        end else begin
            state_q <= state_d;
            frame_q <= frame_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        frame_d = frame_q;
        if (!en) begin
            state_d = ST_OFF;
            frame_d = 1'b0;
        end else if (sw_rst) begin
            state_d = ST_HEAD;
            frame_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_HEAD;
                ST_HEAD: begin
                    if (take) begin
                        if (in_sop && in_dt == DT_FRAME_START) frame_d = 1'b1;
                        if (in_sop && in_dt == DT_FRAME_END)   frame_d = 1'b0;
                        if (!in_eop) begin
                            state_d = (in_sop && hdr_keep) ? ST_PASS : ST_DROP;
                        end
                    end
                end
                ST_PASS: if (take && in_eop) state_d = ST_HEAD;
                ST_DROP: if (take && in_eop) state_d = ST_HEAD;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        out_sop   = 1'b0;
        if (en) begin
            unique case (state_q)
                ST_OFF: in_ready = 1'b1;
                ST_HEAD: begin
                    if (in_sop && hdr_keep) begin
                        out_valid = in_valid;
                        out_sop   = 1'b1;
                        in_ready  = out_ready;
                    end
                end
                ST_PASS: begin
                    out_valid = in_valid;
                    in_ready  = out_ready;
                end
                ST_DROP: in_ready = 1'b1;
            endcase
        end
    end

    assign fs_take   = en && at_head && take && in_sop && (in_dt == DT_FRAME_START);
    assign drop_hdr  = en && at_head && take && in_sop && !hdr_keep;
    assign commit_ok = (state_q == ST_OFF) || (at_head && !frame_q) || fs_take;
endmodule

// File: rtl/csi_dt_filter.sv
`timescale 1ns/1ps
module csi_dt_filter
    import csi_dt_filter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data
);
    logic            en_w;
    logic            sw_rst_w;
    logic            filter_on_w;
    logic [DT_W-1:0] sh_dt_w;
    logic            upd_pend_w;
    logic            commit_ok_w;
    logic            drop_hdr_w;
    logic [CNT_W-1:0] drops_w;

    dtf_cfg_regs #(.REG_W(REG_W), .CNT_W(CNT_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .commit_ok  (commit_ok_w),
        .drop_count (drops_w),
        .en         (en_w),
        .sw_rst     (sw_rst_w),
        .filter_on  (filter_on_w),
        .sh_dt      (sh_dt_w),
        .upd_pend   (upd_pend_w)
    );

    dtf_pkt_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_w),
        .sw_rst    (sw_rst_w),
        .filter_on (filter_on_w),
        .sh_dt     (sh_dt_w),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_dt     (in_data[DT_W-1:0]),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .drop_hdr  (drop_hdr_w),
        .commit_ok (commit_ok_w)
    );

    dtf_sat_counter #(.W(CNT_W)) i_drops (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_rst_w),
        .inc   (drop_hdr_w),
        .value (drops_w)
    );

    assign out_data = in_data;
    assign out_eop  = in_eop;
endmodule

// File: rtl/csi_dt_filter_chk.sv
`timescale 1ns/1ps
module csi_dt_filter_chk
    import csi_dt_filter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              sw_rst,
    input logic              filter_on,
    input logic [DT_W-1:0]   sh_dt,
    input logic              upd_pend,
    input logic              commit_ok,
    input logic [CNT_W-1:0]  drops,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              upd_bit,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_sop,
    input logic [DT_W-1:0]   out_dt
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic upd_write;
    assign upd_write = reg_we && (reg_addr == A_CTRL) && upd_bit;

    p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !out_valid);

    p_type_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && filter_on && out_dt[DT_W-1:DT_W-2] != 2'b00)
        |-> (out_dt == sh_dt));

    p_beat_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);

    p_stall_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |-> (out_valid && !out_ready));

    p_upd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pend && commit_ok && !upd_write) |=> !upd_pend);

    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drops == CNT_TOP && !sw_rst) |=> (drops == CNT_TOP));

    p_cnt_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (drops == '0));
endmodule

bind csi_dt_filter csi_dt_filter_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_w),
    .sw_rst    (sw_rst_w),
    .filter_on (filter_on_w),
    .sh_dt     (sh_dt_w),
    .upd_pend  (upd_pend_w),
    .commit_ok (commit_ok_w),
    .drops     (drops_w),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .upd_bit   (reg_wdata[16]),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sop   (out_sop),
    .out_dt    (out_data[5:0])
);

// File: tb/test_csi_dt_filter.sv
`timescale 1ns/1ps
module test_csi_dt_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [31:0] in_data = 32'd0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_sop;
    logic        out_eop;
    logic [31:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int obn = 0;
    int stalls = 0;
    logic [31:0] ob [0:63];
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    csi_dt_filter i_csi_dt_filter (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
        .out_data(out_data)
    );

    // monitor, mid-cycle
    always @(negedge clk) begin
        if (out_valid && out_ready && obn < 64) begin
            ob[obn] = out_data;
            obn = obn + 1;
        end
        if (in_valid && !in_ready) stalls = stalls + 1;
    end

    function automatic logic [31:0] hdr(input logic [5:0] dt, input logic [15:0] wc);
        return {8'h00, wc, 2'b00, dt};
    endfunction

    function automatic logic [31:0] ctl(input logic en, input logic [1:0] mode, input logic upd);
        return 32'h0000_4000 | {31'd0, en} | ({30'd0, mode} << 10) | ({31'd0, upd} << 16);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic put_beat(input logic [31:0] d, input logic s, input logic e);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        do @(negedge clk); while (!in_ready);
    endtask

    task automatic idle_in;
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_pkt(input logic [5:0] dt, input int n);
        obn = 0;
        stalls = 0;
        put_beat(hdr(dt, 16'(n * 4)), 1'b1, n == 0);
        for (int i = 0; i < n; i++) begin
            put_beat(32'hA500_0000 | {26'd0, dt} << 8 | i, 1'b0, i == n - 1);
        end
        idle_in();
    endtask

    task automatic t_reset;
        rd(2'd0, rv); chk("R1 control reset", rv, 32'h0000_4000);
        rd(2'd1, rv); chk("R1 working type reset", rv, 32'h0000_002C);
        rd(2'd2, rv); chk("R1 counter reset", rv, 32'h0);
        rd(2'd3, rv); chk("R1 shadow reset", rv, 32'h0000_002C);
    endtask

    task automatic t_pass_all;
        wr(2'd0, ctl(1'b1, 2'b00, 1'b1));
        send_pkt(6'h37, 3);
        chk("R2 mode00 keeps 0x37 beat count", obn, 4);
        chk("R2 mode00 header", ob[0], hdr(6'h37, 16'd12));
        wr(2'd0, ctl(1'b1, 2'b10, 1'b1));
        rd(2'd3, rv); chk("R2 reserved mode shadowed", rv, 32'h0000_022C);
        send_pkt(6'h12, 2);
        chk("R2 reserved mode keeps 0x12", obn, 3);
    endtask

    task automatic t_match;
        wr(2'd0, ctl(1'b1, 2'b01, 1'b1));
        rd(2'd3, rv); chk("R7 immediate commit outside frame", rv, 32'h0000_012C);
        send_pkt(6'h2C, 3);
        chk("R3 match beat count", obn, 4);
        chk("R3 match header", ob[0], hdr(6'h2C, 16'd12));
        chk("R3 match last payload", ob[3], 32'hA500_2C02);
    endtask

    task automatic t_mismatch;
        out_ready = 1'b0;
        send_pkt(6'h37, 4);
        out_ready = 1'b1;
        chk("R4 optically black dropped", obn, 0);
        chk("R4 no stall on dropped packet", stalls, 0);
        send_pkt(6'h2A, 0);
        chk("R4 single-beat mismatch dropped", obn, 0);
        rd(2'd2, rv); chk("R10 counter after two drops", rv, 32'd2);
    endtask

    task automatic t_short;
        send_pkt(6'h00, 0);
        chk("R5 frame start passes", obn, 1);
        chk("R5 frame start data", ob[0], hdr(6'h00, 16'd0));
        send_pkt(6'h01, 0);
        chk("R5 frame end passes", obn, 1);
    endtask

    task automatic t_commit_in_frame;
        send_pkt(6'h00, 0);                 // open frame
        wr(2'd1, 32'h0000_002B);
        wr(2'd0, ctl(1'b1, 2'b01, 1'b1));
        rd(2'd0, rv); chk("R7 pending reads 1 inside frame", rv[16], 1'b1);
        rd(2'd3, rv); chk("R7 shadow unchanged inside frame", rv, 32'h0000_012C);
        send_pkt(6'h2B, 1);
        chk("R7 old type still filtering", obn, 0);
        send_pkt(6'h00, 0);                 // next frame start commits
        rd(2'd3, rv); chk("R7 shadow after frame start", rv, 32'h0000_012B);
        rd(2'd0, rv); chk("R7 pending cleared", rv[16], 1'b0);
        send_pkt(6'h2B, 1);
        chk("R7 new type forwarded", obn, 2);
        send_pkt(6'h01, 0);
        wr(2'd1, 32'h0000_002C);
        wr(2'd0, ctl(1'b1, 2'b01, 1'b1));
        rd(2'd3, rv); chk("R7 immediate commit after frame end", rv, 32'h0000_012C);
    endtask

    task automatic t_lanes_spare;
        wr(2'd0, 32'h0000_0701);            // lanes 3, spare 0, mode 01, enable
        rd(2'd0, rv); chk("R8 lanes and spare readback", rv, 32'h0000_0701);
        send_pkt(6'h2C, 1);
        chk("R8 matching still forwarded", obn, 2);
        send_pkt(6'h37, 1);
        chk("R8 mismatch still dropped", obn, 0);
    endtask

    task automatic t_disable;
        wr(2'd0, ctl(1'b0, 2'b01, 1'b0));
        send_pkt(6'h2C, 2);
        chk("R6 nothing out while disabled", obn, 0);
        chk("R6 input consumed while disabled", stalls, 0);
        wr(2'd0, ctl(1'b1, 2'b01, 1'b0));
        send_pkt(6'h2C, 0);
        chk("R6 output resumes after enable", obn, 1);
    endtask

    task automatic t_backpressure;
        obn = 0;
        out_ready = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = hdr(6'h2C, 16'd0); in_sop = 1'b1; in_eop = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 in_ready low under stall", in_ready, 1'b0);
        chk("R11 out_valid held under stall", out_valid, 1'b1);
        @(posedge clk); #1;
        out_ready = 1'b1;
        @(negedge clk);
        chk("R11 in_ready follows out_ready", in_ready, 1'b1);
        idle_in();
        chk("R11 beat delivered once", obn, 1);
    endtask

    task automatic t_swreset;
        send_pkt(6'h00, 0);                 // open frame
        wr(2'd0, ctl(1'b1, 2'b01, 1'b0) | 32'h2);
        rd(2'd0, rv); chk("R9 reset bit reads 0", rv, 32'h0000_4401);
        rd(2'd2, rv); chk("R9 counter cleared", rv, 32'd0);
        wr(2'd1, 32'h0000_0037);
        wr(2'd0, ctl(1'b1, 2'b01, 1'b1));
        rd(2'd3, rv); chk("R9 frame tracking cleared", rv, 32'h0000_0137);
        send_pkt(6'h37, 1);
        chk("R9 filtering after reset", obn, 2);
        wr(2'd1, 32'h0000_002C);
        wr(2'd0, ctl(1'b1, 2'b01, 1'b1));
    endtask

    task automatic t_saturate;
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = hdr(6'h37, 16'd0); in_sop = 1'b1; in_eop = 1'b1;
        repeat (65540) @(posedge clk);
        #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        rd(2'd2, rv); chk("R10 counter saturates", rv, 32'h0000_FFFF);
        wr(2'd0, ctl(1'b1, 2'b01, 1'b0) | 32'h2);
        rd(2'd2, rv); chk("R9 reset clears saturated counter", rv, 32'd0);
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_pass_all();
        t_match();
        t_mismatch();
        t_short();
        t_commit_in_frame();
        t_lanes_spare();
        t_disable();
        t_backpressure();
        t_swreset();
        t_saturate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule